// File: doc/BRIEF.md
# Cartridge ROM Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and a cartridge ROM plus 8 KB of work RAM. The lowest 16 KB of CPU space always shows the first ROM page. The next two 16 KB windows each show a ROM page picked by a bank register. The top 16 KB holds the work RAM, which appears twice because only the low 13 address bits index it.

The two bank registers are not separate I/O. They are the top bytes of the RAM mirror. A CPU store to one of those addresses writes the RAM byte as usual and also loads the matching bank register on the same clock edge. Before a bank number is used it is cut to the pages the ROM really has. The mask used for this comes from the ROM size exponent, a parameter fixed at elaboration. The address outputs are combinational from the CPU address and the registered bank numbers.

Top module: `rom_bank_mapper`

## Requirements
- R1: Addresses 0x0000–0xBFFF assert `rom_sel_o` and deassert `ram_en_o`. Addresses 0xC000–0xFFFF do the opposite.
- R2: In 0xC000–0xFFFF, `ram_addr_o` equals addr[12:0], so 0xC000+n and 0xE000+n reach the same RAM byte.
- R3: `ram_we_o` is high only for a write inside 0xC000–0xFFFF. A write below 0xC000 raises no write strobe and leaves both windows unchanged.
- R4: For 0x0000–0x3FFF, `rom_addr_o` equals addr[13:0] with zeros above, whatever the bank registers hold.
- R5: A write to 0xFFFE loads the window-1 bank register. Window 1 covers 0x4000–0x7FFF.
- R6: A write to 0xFFFF loads the window-2 bank register. Window 2 covers 0x8000–0xBFFF.
- R7: In a switchable window, `rom_addr_o` = ((bank AND mask) << 14) OR addr[13:0]. Here mask = (2^ROM_LOG2 − 1) >> 14.
- R8: While reset is held, and after it until the first load, window 1 uses bank 1 and window 2 uses bank 2. The mask still applies to these values.
- R9: Writes to 0xFFF8–0xFFFD leave both windows unchanged. So do writes at any other address below 0xFFF8 whose low nibble is 0xE or 0xF.
- R10: A write to 0xFFFE or 0xFFFF also raises `ram_we_o`, with `ram_addr_o` equal to addr[12:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| we_i | input | 1 | CPU write strobe |
| wdata_i | input | 8 | CPU write data |
| rom_sel_o | output | 1 | Access targets ROM |
| rom_addr_o | output | ROM_LOG2 | ROM byte address |
| ram_en_o | output | 1 | Access targets work RAM |
| ram_we_o | output | 1 | Work RAM write strobe |
| ram_addr_o | output | 13 | Work RAM byte address |

## Verification
The bench builds two copies of the block and drives both with the same stimulus. One uses ROM_LOG2 = 18, which gives a four-bit mask, so bank numbers above 15 visibly wrap. The other uses ROM_LOG2 = 15, the smallest allowed. Its one-bit mask turns the reset value 2 of window 2 into page 0, which tests that masking also applies to the reset values. Comparing both against one behavioural model catches a mask or an address width that is wired for a single size only.

// File: rtl/rom_map_pkg.sv
package rom_map_pkg;
  localparam int CPU_AW  = 16;
  localparam int PAGE_AW = 14;
  localparam int RAM_AW  = 13;
  localparam int BANK_W  = 8;
  localparam int NUM_WIN = 2;

  typedef logic [BANK_W-1:0] bank_t;

  // window w powers up showing page w+1
  function automatic bank_t win_reset(input int w);
    return bank_t'(w + 1);
  endfunction
endpackage

// File: rtl/rom_map_decode.sv
module rom_map_decode
  import rom_map_pkg::*;
(
  input  logic [CPU_AW-1:0]  addr_i,
  input  logic               we_i,
  output logic               rom_sel_o,
  output logic               ram_en_o,
  output logic               ram_we_o,
  output logic [NUM_WIN-1:0] bank_we_o
);
  logic reg_hit;

  always_comb begin
    ram_en_o  = (addr_i[CPU_AW-1 -: 2] == 2'b11);
    rom_sel_o = ~ram_en_o;
    ram_we_o  = we_i & ram_en_o;
    reg_hit   = we_i & (&addr_i[CPU_AW-1:3]);
  end

  // windows take the last slots of the 8-byte register area
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_dec
    localparam logic [2:0] SLOT = 3'(8 - NUM_WIN + w);
    assign bank_we_o[w] = reg_hit & (addr_i[2:0] == SLOT);
  end
endmodule

// File: rtl/rom_map_bank_regs.sv
module rom_map_bank_regs
  import rom_map_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_WIN-1:0]             bank_we_i,
  input  bank_t                          wdata_i,
  output logic [NUM_WIN-1:0][BANK_W-1:0] bank_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_bank
    bank_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           q <= win_reset(w);
      else if (bank_we_i[w]) q <= wdata_i;
    end
    assign bank_o[w] = q;
  end
endmodule

// File: rtl/rom_map_rom_addr.sv
module rom_map_rom_addr
  import rom_map_pkg::*;
#(
  parameter int ROM_LOG2 = 18
) (
  input  logic [CPU_AW-1:0]              addr_i,
  input  logic [NUM_WIN-1:0][BANK_W-1:0] bank_i,
  output logic [ROM_LOG2-1:0]            rom_addr_o
);
  localparam bank_t BANK_MASK = bank_t'(((64'd1 << ROM_LOG2) - 64'd1) >> PAGE_AW);

  bank_t page;

  always_comb begin
    unique case (addr_i[CPU_AW-1 -: 2])
      2'b01:   page = bank_i[0];
      2'b10:   page = bank_i[1];
      default: page = '0;  // fixed page 0; RAM area is don't-care
    endcase
    rom_addr_o = ROM_LOG2'({page & BANK_MASK, addr_i[PAGE_AW-1:0]});
  end
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
  import rom_map_pkg::*;
#(
  parameter int ROM_LOG2 = 18  // 15..22
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [15:0]         addr_i,
  input  logic                we_i,
  input  logic [7:0]          wdata_i,
  output logic                rom_sel_o,
  output logic [ROM_LOG2-1:0] rom_addr_o,
  output logic                ram_en_o,
  output logic                ram_we_o,
  output logic [12:0]         ram_addr_o
);
  logic [NUM_WIN-1:0]             bank_we;
  logic [NUM_WIN-1:0][BANK_W-1:0] bank_q;

  rom_map_decode u_decode (
    .addr_i    (addr_i),
    .we_i      (we_i),
    .rom_sel_o (rom_sel_o),
    .ram_en_o  (ram_en_o),
    .ram_we_o  (ram_we_o),
    .bank_we_o (bank_we)
  );

  rom_map_bank_regs u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bank_we_i (bank_we),
    .wdata_i   (wdata_i),
    .bank_o    (bank_q)
  );

  rom_map_rom_addr #(.ROM_LOG2(ROM_LOG2)) u_rom_addr (
    .addr_i     (addr_i),
    .bank_i     (bank_q),
    .rom_addr_o (rom_addr_o)
  );

  assign ram_addr_o = addr_i[RAM_AW-1:0];
endmodule

// File: rtl/rom_map_sva.sv
module rom_map_sva
  import rom_map_pkg::*;
#(
  parameter int ROM_LOG2 = 18
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [15:0]                    addr_i,
  input logic                           we_i,
  input logic [7:0]                     wdata_i,
  input logic                           rom_sel_o,
  input logic [ROM_LOG2-1:0]            rom_addr_o,
  input logic                           ram_en_o,
  input logic                           ram_we_o,
  input logic [NUM_WIN-1:0][BANK_W-1:0] bank_q
);
  a_r1_region_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({rom_sel_o, ram_en_o}));

  a_r3_strobe_needs_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (we_i && ram_en_o && addr_i[15:14] == 2'b11));

  a_r4_page0_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00) |-> (rom_addr_o == ROM_LOG2'(addr_i[13:0])));

  a_r5_win1_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 16'hFFFE) |=> (bank_q[0] == $past(wdata_i)));

  a_r6_win2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 16'hFFFF) |=> (bank_q[1] == $past(wdata_i)));

  a_r9_banks_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i[15:1] == 15'h7FFF) |=> $stable(bank_q));

  a_r10_reg_write_hits_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[15:1] == 15'h7FFF) |-> ram_we_o);
endmodule

bind rom_bank_mapper rom_map_sva #(.ROM_LOG2(ROM_LOG2)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rom_sel_o  (rom_sel_o),
  .rom_addr_o (rom_addr_o),
  .ram_en_o   (ram_en_o),
  .ram_we_o   (ram_we_o),
  .bank_q     (bank_q)
);

// File: tb/rom_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module rom_bank_mapper_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  wdata_i = '0;

  logic        big_rom_sel, big_ram_en, big_ram_we;
  logic [17:0] big_rom_addr;
  logic [12:0] big_ram_addr;
  logic        sml_rom_sel, sml_ram_en, sml_ram_we;
  logic [14:0] sml_rom_addr;
  logic [12:0] sml_ram_addr;

  int n_chk = 0;
  int n_bad = 0;
  int b1 = 1;
  int b2 = 2;

  always #4 clk_i = ~clk_i;

  rom_bank_mapper #(.ROM_LOG2(18)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .rom_sel_o(big_rom_sel), .rom_addr_o(big_rom_addr), .ram_en_o(big_ram_en),
    .ram_we_o(big_ram_we), .ram_addr_o(big_ram_addr));

  rom_bank_mapper #(.ROM_LOG2(15)) dut_small_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .rom_sel_o(sml_rom_sel), .rom_addr_o(sml_rom_addr), .ram_en_o(sml_ram_en),
    .ram_we_o(sml_ram_we), .ram_addr_o(sml_ram_addr));

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rom(input int a, input int mask, input int aw);
    int pg = a >> 14;
    int bk = (pg == 1) ? b1 : (pg == 2) ? b2 : 0;
    return (((bk & mask) << 14) | (a & 16'h3FFF)) & ((1 << aw) - 1);
  endfunction

  task automatic step(input int a, input bit w, input int d, input string tag);
    bit in_ram;
    @(negedge clk_i);
    addr_i = 16'(a); we_i = w; wdata_i = 8'(d);
    #1;
    in_ram = (a >= 16'hC000);
    check(tag, "big rom_sel (R1)", int'(big_rom_sel), int'(!in_ram));
    check(tag, "big ram_en (R1)", int'(big_ram_en), int'(in_ram));
    check(tag, "big ram_we (R3)", int'(big_ram_we), int'(w && in_ram));
    check(tag, "sml rom_sel (R1)", int'(sml_rom_sel), int'(!in_ram));
    check(tag, "sml ram_we (R3)", int'(sml_ram_we), int'(w && in_ram));
    if (in_ram) begin
      check(tag, "big ram_addr (R2)", int'(big_ram_addr), a & 16'h1FFF);
      check(tag, "sml ram_addr (R2)", int'(sml_ram_addr), a & 16'h1FFF);
    end else begin
      check(tag, "big rom_addr (R7)", int'(big_rom_addr), exp_rom(a, 15, 18));
      check(tag, "sml rom_addr (R7)", int'(sml_rom_addr), exp_rom(a, 1, 15));
    end
    if (w && rst_ni && a >= 16'hFFF8) begin
      if ((a & 15) == 14) b1 = d & 255;
      else if ((a & 15) == 15) b2 = d & 255;
    end
  endtask

  task automatic read_windows(input string tag);
    step(16'h4123, 1'b0, 0, tag);
    step(16'hBABC, 1'b0, 0, tag);
  endtask

  initial begin
    // R8: values seen while reset is held
    step(16'h4000, 1'b0, 0, "R8");
    step(16'h8001, 1'b0, 0, "R8");
    @(negedge clk_i); rst_ni = 1'b1;
    step(16'h7FFF, 1'b0, 0, "R8");
    step(16'hBFFF, 1'b0, 0, "R8");
    step(16'h0000, 1'b0, 0, "R4");
    step(16'h3FFF, 1'b0, 0, "R4");
    step(16'hC000, 1'b0, 0, "R2");
    step(16'hE000, 1'b0, 0, "R2");
    step(16'hDFFF, 1'b0, 0, "R2");
    step(16'hFFFF, 1'b0, 0, "R2");
    step(16'h1234, 1'b1, 8'h77, "R3");
    step(16'hBFFE, 1'b1, 8'h33, "R3");
    step(16'h7FFF, 1'b1, 8'h44, "R3");
    read_windows("R3");
    step(16'hFFFE, 1'b1, 8'h05, "R5/R10");
    read_windows("R5");
    step(16'hFFFF, 1'b1, 8'h37, "R6/R10");
    read_windows("R6");
    step(16'h2ABC, 1'b0, 0, "R4");
    step(16'hFFFE, 1'b1, 8'hFA, "R7/R10");
    read_windows("R7");
    step(16'hFFFC, 1'b1, 8'h55, "R9");
    step(16'hFFFD, 1'b1, 8'h03, "R9");
    step(16'hFFF8, 1'b1, 8'h09, "R9");
    step(16'hFFEE, 1'b1, 8'h0A, "R9");
    step(16'hDFFF, 1'b1, 8'h0B, "R9");
    read_windows("R9");
    begin
      int lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        int a;
        lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
        a = (i % 5 == 0) ? (16'hFFF8 | (lfsr & 7)) : lfsr;
        step(a, lfsr[3], (lfsr >> 5) & 255, "R7");
      end
    end
    @(negedge clk_i); we_i = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule